// File: doc/BRIEF.md
# Virtually indexed, physically tagged write-back data cache

This block is a direct-mapped first-level data cache of 8 KiB with a write-back policy. A load or store arrives with a virtual address. In one cycle the block reads the tag and data arrays at the virtual line index, looks up the virtual page number in a small fully associative translation table, and compares the stored physical tag with the translated page number. On a hit, a load returns its aligned and extended result in the next cycle. On a hit, a store merges its byte lanes into the line and marks the line dirty.

With 4 KiB pages and 16-byte lines, the top index bit is a virtual page bit. For this reason every stored tag holds the whole physical page number, including the physical copy of that bit. A dirty victim's memory address is then built from the stored tag and the index bits that lie inside the page offset. No translation is needed at eviction time.

A translation miss raises a flag and holds the request until the table is refilled through its own port. A cache miss writes back a dirty victim first, then fetches the line and replays the request. A store miss therefore allocates the line and then merges into it.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid and clean and the translation table is empty. The first access to any address misses and fetches from memory without writing anything back. With no request, `stall`, `tlb_miss`, `rsp_valid` and `mem_req_valid` are low.
- R2: If the virtual page number (address bits 31:12) has no entry, `tlb_miss` and `stall` are high and no memory request is issued until a refill is written. Refills go to the entries in round-robin order, so with 4 entries the fifth refill replaces the first.
- R3: A request hits when its line is valid and the stored 20-bit tag equals the translated physical page number. A hit is accepted with `stall` low in the same cycle. A load's `rsp_valid` pulses in the next cycle only, and stores give no response.
- R4: `req_size` 0 is a byte at lane `addr[1:0]`, 1 is a halfword at `addr[1]`, and 2 is a word. `req_unsigned` set zero-extends and clear sign-extends.
- R5: A store hit writes only the lanes selected by size and low address bits, marks the line dirty and causes no memory traffic.
- R6: A miss on a clean or invalid line issues one read of the line at physical address {page number, vaddr[11:4], 0000}, installs it clean, then serves the held request.
- R7: A miss on a dirty line first writes it back at {stored tag, index bits 7:0, 0000}, where physical bit 12 comes from the tag and not from the virtual index. The read follows the write-back.
- R8: A store miss allocates: the line is fetched, the store is merged into it and the line becomes dirty, so a later eviction writes the merged bytes.
- R9: A memory request keeps `mem_req_valid`, `mem_req_we` and `mem_req_addr` steady until `mem_req_ready`. Byte k of a line sits at bits 8k+7:8k of the line-wide data buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present, held while stalled |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_unsigned | input | 1 | Zero-extend load result |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| stall | output | 1 | Request not accepted this cycle |
| tlb_miss | output | 1 | Page number has no translation |
| rsp_valid | output | 1 | Load result valid |
| rsp_rdata | output | 32 | Aligned load result |
| tlb_fill_valid | input | 1 | Write a translation entry |
| tlb_fill_vpn | input | 20 | Virtual page number to map |
| tlb_fill_ppn | input | 20 | Physical page number |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write-back, 0 = line fetch |
| mem_req_addr | output | 32 | Physical line address |
| mem_req_wdata | output | 128 | Write-back line |
| mem_rsp_valid | input | 1 | Fetched line present |
| mem_rsp_rdata | input | 128 | Fetched line |

## Verification
The bench uses the default parameters: 8 KiB capacity, 16-byte lines, 4 KiB pages and a 4-entry table. With these values exactly one index bit lies above the page offset. The bench maps a virtual page whose bit 12 is set onto a physical page whose bit 0 is clear, so a write-back address that took bit 12 from the index instead of the tag would point to the wrong line. Five distinct pages are enough to wrap the round-robin table and observe a replaced translation.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FETCH,
        ST_WAIT
    } fsm_e;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [PTR_W-1:0]              ptr;
    } tlb_s;

    tlb_s q, d;
    logic [ENTRIES-1:0] match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = q.vld[e] && (q.vpn[e] == lk_vpn);
    end

    always_comb begin
        lk_hit = |match;
        lk_ppn = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) lk_ppn = lk_ppn | q.ppn[e];
        end
    end

    always_comb begin
        d = q;
        if (fill_valid) begin
            d.vld[q.ptr] = 1'b1;
            d.vpn[q.ptr] = fill_vpn;
            d.ppn[q.ptr] = fill_ppn;
            d.ptr = (q.ptr == PTR_W'(ENTRIES - 1)) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/vipt_lanes.sv
module vipt_lanes
    import vipt_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [1:0]        off,
    input  logic [1:0]        size,
    input  logic              unsigned_ld,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ld_data,
    output logic [WORD_W-1:0] st_word
);
    logic [7:0]  sel_b;
    logic [15:0] sel_h;
    logic [3:0]  be;
    logic [WORD_W-1:0] rep;

    always_comb begin
        sel_b = word_in[8*off +: 8];
        sel_h = off[1] ? word_in[31:16] : word_in[15:0];
        case (size)
            SZ_BYTE: ld_data = unsigned_ld ? {24'd0, sel_b} : {{24{sel_b[7]}}, sel_b};
            SZ_HALF: ld_data = unsigned_ld ? {16'd0, sel_h} : {{16{sel_h[15]}}, sel_h};
            default: ld_data = word_in;
        endcase

        case (size)
            SZ_BYTE: begin be = 4'b0001 << off; rep = {4{wdata[7:0]}}; end
            SZ_HALF: begin be = off[1] ? 4'b1100 : 4'b0011; rep = {2{wdata[15:0]}}; end
            default: begin be = 4'b1111; rep = wdata; end
        endcase
        for (int k = 0; k < 4; k++) begin
            st_word[8*k +: 8] = be[k] ? rep[8*k +: 8] : word_in[8*k +: 8];
        end
    end
endmodule

// File: rtl/vipt_arrays.sv
module vipt_arrays #(
    parameter int LINES  = 512,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic                     rd_vld,
    output logic                     rd_dirty,
    output logic [TAG_W-1:0]         rd_tag,
    output logic [LINE_W-1:0]        rd_data,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic                     wr_dirty,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [LINE_W-1:0]        wr_data
);
    logic [LINES-1:0]  vld_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [LINE_W-1:0] data_mem [LINES];

    assign rd_vld   = vld_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_data  = data_mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q   <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx]   <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
    import vipt_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 8192,
    parameter int LINE_BYTES  = 16,
    parameter int PAGE_BYTES  = 4096,
    parameter int TLB_ENTRIES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_we,
    input  logic [1:0]                 req_size,
    input  logic                       req_unsigned,
    input  logic [ADDR_W-1:0]          req_vaddr,
    input  logic [WORD_W-1:0]          req_wdata,
    output logic                       stall,
    output logic                       tlb_miss,
    output logic                       rsp_valid,
    output logic [WORD_W-1:0]          rsp_rdata,
    input  logic                       tlb_fill_valid,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] tlb_fill_vpn,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] tlb_fill_ppn,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic                       mem_req_we,
    output logic [ADDR_W-1:0]          mem_req_addr,
    output logic [8*LINE_BYTES-1:0]    mem_req_wdata,
    input  logic                       mem_rsp_valid,
    input  logic [8*LINE_BYTES-1:0]    mem_rsp_rdata
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int PG_W   = $clog2(PAGE_BYTES);
    localparam int LINES  = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W  = $clog2(LINES);
    localparam int PN_W   = ADDR_W - PG_W;
    localparam int LINE_W = 8 * LINE_BYTES;
    localparam int WORDS  = LINE_BYTES / 4;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int LOW_W  = PG_W - OFF_W;

    typedef struct packed {
        fsm_e              st;
        logic [PN_W-1:0]   ppn;
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_d;
    } ctl_s;

    ctl_s q, d;

    logic [IDX_W-1:0]  idx;
    logic [WSEL_W-1:0] wsel;
    logic              t_hit, l_vld, l_dirty, c_hit;
    logic [PN_W-1:0]   t_ppn, l_tag;
    logic [LINE_W-1:0] l_data, merged;
    logic [WORD_W-1:0] hit_word, ld_data, st_word;
    logic              arr_we, arr_dirty;
    logic [PN_W-1:0]   arr_tag;
    logic [LINE_W-1:0] arr_data;

    assign idx  = req_vaddr[OFF_W+IDX_W-1:OFF_W];
    assign wsel = req_vaddr[OFF_W-1:2];

    vipt_tlb #(.VPN_W(PN_W), .PPN_W(PN_W), .ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(req_vaddr[ADDR_W-1:PG_W]), .lk_hit(t_hit), .lk_ppn(t_ppn),
        .fill_valid(tlb_fill_valid), .fill_vpn(tlb_fill_vpn), .fill_ppn(tlb_fill_ppn)
    );

    vipt_arrays #(.LINES(LINES), .TAG_W(PN_W), .LINE_W(LINE_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(idx), .rd_vld(l_vld), .rd_dirty(l_dirty), .rd_tag(l_tag), .rd_data(l_data),
        .wr_en(arr_we), .wr_idx(idx), .wr_dirty(arr_dirty), .wr_tag(arr_tag), .wr_data(arr_data)
    );

    vipt_lanes u_lanes (
        .word_in(hit_word), .off(req_vaddr[1:0]), .size(req_size),
        .unsigned_ld(req_unsigned), .wdata(req_wdata),
        .ld_data(ld_data), .st_word(st_word)
    );

    assign c_hit = l_vld && (l_tag == t_ppn);

    always_comb begin
        hit_word = '0;
        merged   = l_data;
        for (int w = 0; w < WORDS; w++) begin
            if (wsel == WSEL_W'(w)) begin
                hit_word = l_data[32*w +: 32];
                merged[32*w +: 32] = st_word;
            end
        end
    end

    always_comb begin
        d             = q;
        d.rsp_v       = 1'b0;
        stall         = req_valid;
        tlb_miss      = 1'b0;
        arr_we        = 1'b0;
        arr_dirty     = 1'b0;
        arr_tag       = l_tag;
        arr_data      = merged;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = {q.ppn, req_vaddr[PG_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_req_wdata = l_data;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!t_hit) begin
                        tlb_miss = 1'b1;
                    end else if (c_hit) begin
                        stall = 1'b0;
                        if (req_we) begin
                            arr_we    = 1'b1;
                            arr_dirty = 1'b1;
                        end else begin
                            d.rsp_v = 1'b1;
                            d.rsp_d = ld_data;
                        end
                    end else begin
                        d.ppn = t_ppn;
                        d.st  = (l_vld && l_dirty) ? ST_WBACK : ST_FETCH;
                    end
                end
            end
            ST_WBACK: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = {l_tag, idx[LOW_W-1:0], {OFF_W{1'b0}}};
                if (mem_req_ready) d.st = ST_FETCH;
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) d.st = ST_WAIT;
            end
            default: begin
                if (mem_rsp_valid) begin
                    arr_we   = 1'b1;
                    arr_tag  = q.ppn;
                    arr_data = mem_rsp_rdata;
                    d.st     = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.ppn   <= '0;
            q.rsp_v <= 1'b0;
            q.rsp_d <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rsp_d;
endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic              stall,
    input logic              tlb_miss,
    input logic              rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr
);
    // R2
    tlb_miss_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_miss |-> (stall && !mem_req_valid));

    // R3
    load_rsp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stall && !req_we) |=> rsp_valid);

    // R3
    rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !stall && !req_we));

    // R5
    store_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stall && req_we) |=> !rsp_valid);

    // R6
    mem_only_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> stall);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));
endmodule

bind vipt_dcache vipt_dcache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_vipt_dcache.sv
module tb_vipt_dcache;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_we = 0, req_unsigned = 0;
    logic [1:0] req_size = 0;
    logic [31:0] req_vaddr = 0, req_wdata = 0;
    logic stall, tlb_miss, rsp_valid;
    logic [31:0] rsp_rdata;
    logic tlb_fill_valid = 0;
    logic [19:0] tlb_fill_vpn = 0, tlb_fill_ppn = 0;
    logic mem_req_valid, mem_req_we;
    logic mem_req_ready = 0;
    logic [31:0] mem_req_addr;
    logic [127:0] mem_req_wdata;
    logic mem_rsp_valid = 0;
    logic [127:0] mem_rsp_rdata = 0;

    always #2 clk = ~clk;

    vipt_dcache dut (.*);

    int checks = 0, fails = 0;
    bit done = 0, mon_en = 0;

    logic [7:0]  pmem  [int unsigned];
    logic [7:0]  ref_b [int unsigned];
    logic [19:0] ptab  [int unsigned];

    typedef struct { bit we; logic [31:0] a; } ev_t;
    ev_t evlog[$];

    function automatic logic [7:0] init_byte(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hC3;
    endfunction
    function automatic logic [7:0] mem_at(logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : init_byte(a);
    endfunction
    function automatic logic [7:0] ref_at(logic [31:0] a);
        return ref_b.exists(a) ? ref_b[a] : init_byte(a);
    endfunction
    function automatic logic [31:0] xlate(logic [31:0] va);
        return {ptab[va[31:12]], va[11:0]};
    endfunction

    function automatic logic [31:0] ref_load(logic [31:0] va, logic [1:0] sz, bit uns);
        logic [31:0] pa = xlate(va);
        logic [7:0] b;
        logic [15:0] h;
        if (sz == 2'd0) begin
            b = ref_at(pa);
            return uns ? {24'd0, b} : {{24{b[7]}}, b};
        end else if (sz == 2'd1) begin
            pa[0] = 1'b0;
            h = {ref_at(pa + 1), ref_at(pa)};
            return uns ? {16'd0, h} : {{16{h[15]}}, h};
        end
        pa[1:0] = 2'b00;
        return {ref_at(pa + 3), ref_at(pa + 2), ref_at(pa + 1), ref_at(pa)};
    endfunction

    task automatic ref_store(logic [31:0] va, logic [1:0] sz, logic [31:0] wd);
        logic [31:0] pa = xlate(va);
        int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        if (sz == 2'd1) pa[0] = 1'b0;
        if (sz == 2'd2) pa[1:0] = 2'b00;
        for (int k = 0; k < n; k++) ref_b[pa + k] = wd[8*k +: 8];
    endtask

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural model
    logic exp_rv = 0;
    logic [31:0] exp_rd = 0, last_rd = 0;
    always @(negedge clk) begin
        #1;
        if (rst_n && mon_en) begin
            chk(rsp_valid === exp_rv, "R3", "rsp_valid timing", {31'd0, rsp_valid}, {31'd0, exp_rv});
            if (exp_rv) begin
                chk(rsp_rdata === exp_rd, "R4", "load data", rsp_rdata, exp_rd);
                last_rd = rsp_rdata;
            end
            exp_rv = 0;
            if (req_valid && !stall) begin
                if (!req_we) begin
                    exp_rv = 1;
                    exp_rd = ref_load(req_vaddr, req_size, req_unsigned);
                end else begin
                    ref_store(req_vaddr, req_size, req_wdata);
                end
            end
        end
    end

    // line-wide memory responder
    initial begin
        logic [31:0] a;
        logic w;
        logic [127:0] dat;
        int hold;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && mem_req_valid) begin
                a = mem_req_addr; w = mem_req_we; dat = mem_req_wdata;
                hold = evlog.size() % 3;
                for (int i = 0; i < hold; i++) begin
                    @(negedge clk);
                    #1;
                    chk(mem_req_valid && mem_req_addr == a && mem_req_we == w, "R9",
                        "request held", mem_req_addr, a);
                end
                mem_req_ready = 1;
                @(negedge clk);
                mem_req_ready = 0;
                evlog.push_back('{w, a});
                if (w) begin
                    for (int k = 0; k < 16; k++) begin
                        chk(dat[8*k +: 8] == ref_at(a + k), "R7", "write-back byte",
                            {24'd0, dat[8*k +: 8]}, {24'd0, ref_at(a + k)});
                        pmem[a + k] = dat[8*k +: 8];
                    end
                end else begin
                    @(negedge clk);
                    for (int k = 0; k < 16; k++) mem_rsp_rdata[8*k +: 8] = mem_at(a + k);
                    mem_rsp_valid = 1;
                    @(negedge clk);
                    mem_rsp_valid = 0;
                end
            end
        end
    end

    int last_stalls, last_tmiss;

    task automatic access(logic [31:0] va, bit we, logic [1:0] sz, bit uns, logic [31:0] wd);
        last_stalls = 0;
        last_tmiss = 0;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_we = we; req_size = sz;
        req_unsigned = uns; req_wdata = wd;
        #1;
        while (stall) begin
            if (tlb_miss) begin
                last_tmiss++;
                chk(!mem_req_valid, "R2", "no memory traffic on translation miss",
                    {31'd0, mem_req_valid}, 32'd0);
                tlb_fill_valid = 1;
                tlb_fill_vpn = va[31:12];
                tlb_fill_ppn = ptab[va[31:12]];
                @(negedge clk);
                tlb_fill_valid = 0;
            end else begin
                last_stalls++;
                @(negedge clk);
            end
            #1;
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        mon_en = 0;
        exp_rv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        ref_b = pmem;
        mon_en = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        ptab[32'h10] = 20'h00200;
        ptab[32'h11] = 20'h00300;
        ptab[32'h31] = 20'h00500;
        ptab[32'h20] = 20'h00301;
        ptab[32'h40] = 20'h00600;

        do_reset();
        #1;
        // R1: idle outputs after reset
        chk(!stall && !tlb_miss && !rsp_valid && !mem_req_valid, "R1", "idle after reset",
            {28'd0, stall, tlb_miss, rsp_valid, mem_req_valid}, 32'd0);

        // R2 / R6: first load misses both structures
        access(32'h0001_0040, 0, 2'd2, 0, 0);
        chk(last_tmiss == 1, "R2", "translation miss count", last_tmiss, 1);
        chk(evlog.size() == 1 && !evlog[$].we && evlog[$].a == 32'h0020_0040, "R6",
            "line fetch address", evlog[$].a, 32'h0020_0040);
        chk(evlog.size() == 1, "R1", "no write-back after reset", evlog.size(), 1);

        // R3: same line hits without stall
        access(32'h0001_0044, 0, 2'd2, 0, 0);
        chk(last_stalls == 0 && last_tmiss == 0, "R3", "hit stall cycles", last_stalls, 0);

        // R5 / R4: lane-wise stores on a resident line
        n = evlog.size();
        access(32'h0001_0048, 1, 2'd2, 0, 32'h1122_3344);
        access(32'h0001_004A, 1, 2'd1, 0, 32'h0000_BEEF);
        access(32'h0001_0049, 1, 2'd0, 0, 32'h0000_00A5);
        access(32'h0001_0048, 0, 2'd2, 0, 0);
        #2;
        chk(last_rd == 32'hBEEF_A544, "R5", "merged lanes", last_rd, 32'hBEEF_A544);
        chk(evlog.size() == n, "R5", "store hits stay on chip", evlog.size(), n);
        access(32'h0001_004A, 0, 2'd1, 0, 0);
        #2;
        chk(last_rd == 32'hFFFF_BEEF, "R4", "signed half", last_rd, 32'hFFFF_BEEF);
        access(32'h0001_004A, 0, 2'd1, 1, 0);
        #2;
        chk(last_rd == 32'h0000_BEEF, "R4", "unsigned half", last_rd, 32'h0000_BEEF);
        access(32'h0001_0041, 1, 2'd0, 0, 32'h0000_0080);
        access(32'h0001_0041, 0, 2'd0, 0, 0);
        #2;
        chk(last_rd == 32'hFFFF_FF80, "R4", "signed byte", last_rd, 32'hFFFF_FF80);
        access(32'h0001_0041, 0, 2'd0, 1, 0);
        #2;
        chk(last_rd == 32'h0000_0080, "R4", "unsigned byte", last_rd, 32'h0000_0080);

        // R7: dirty victim under the overlapping index bit
        access(32'h0001_10C0, 1, 2'd2, 0, 32'hCAFE_F00D);
        n = evlog.size();
        access(32'h0003_10C4, 0, 2'd2, 0, 0);
        chk(evlog.size() == n + 2, "R7", "events on dirty miss", evlog.size(), n + 2);
        chk(evlog[$-1].we && evlog[$-1].a == 32'h0030_00C0, "R7", "write-back address from tag",
            evlog[$-1].a, 32'h0030_00C0);
        chk(!evlog[$].we && evlog[$].a == 32'h0050_00C0, "R7", "fetch follows write-back",
            evlog[$].a, 32'h0050_00C0);

        // R8: store miss allocates and dirties the line
        n = evlog.size();
        access(32'h0002_0204, 1, 2'd0, 0, 32'h0000_005E);
        chk(evlog.size() == n + 1 && !evlog[$].we && evlog[$].a == 32'h0030_1200, "R8",
            "store miss fetch", evlog[$].a, 32'h0030_1200);
        access(32'h0001_0200, 0, 2'd2, 0, 0);
        chk(evlog[$-1].we && evlog[$-1].a == 32'h0030_1200, "R8", "allocated line written back",
            evlog[$-1].a, 32'h0030_1200);

        // R2: round-robin replacement after the fifth page
        access(32'h0004_0000, 0, 2'd2, 0, 0);
        chk(last_tmiss == 1, "R2", "fifth page misses", last_tmiss, 1);
        access(32'h0001_10C0, 0, 2'd2, 0, 0);
        chk(last_tmiss == 0, "R2", "second entry kept", last_tmiss, 0);
        access(32'h0001_0040, 0, 2'd2, 0, 0);
        chk(last_tmiss == 1, "R2", "first entry replaced", last_tmiss, 1);

        // R1: reset drops valid and dirty state
        access(32'h0001_0040, 1, 2'd2, 0, 32'h7777_7777);
        do_reset();
        n = evlog.size();
        access(32'h0001_0040, 0, 2'd2, 0, 0);
        chk(last_tmiss == 1, "R1", "table empty after reset", last_tmiss, 1);
        chk(evlog.size() == n + 1 && !evlog[$].we, "R1", "refetch without write-back",
            evlog.size(), n + 1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule